// File: doc/BRIEF.md
# Periodic Millisecond Timer Interrupt

This block is a programmable down-counting timer that driver software uses to get a periodic wake-up for housekeeping work. Through a simple register write port, software stores a duration, a loop flag and an interrupt enable. A write with the kick-start bit set loads an internal counter and starts it. The counter then steps down once per millisecond tick. The tick comes either from an external tick input or from a prescaler that divides the core clock. This choice is made at elaboration time.

When the counter runs out, the block sets a sticky timer cause bit and, if the enable is set, asserts an interrupt request. In loop mode the counter reloads and keeps going. In one-shot mode it stops. Software acknowledges the event by writing 1 to the clear bit of the cause register. The current count and a running flag are brought out so that the surrounding logic can observe progress.

Top module: `ms_timer_irq`

## Requirements
- R1: After synchronous reset, `running`, `count_now`, `cause` and `irq` are all 0. The stored duration, loop flag and enable are also 0.
- R2: Kick-start is a write to address 0 with `wr_data[31]`=1. If the duration field `wr_data[DUR_W-1:0]` of that write is nonzero, then from the next cycle `count_now` equals that duration and `running` is 1.
- R3: While `running` is 1 and no kick-start write occurs, each cycle with a millisecond tick lowers `count_now` by one. A cycle without a tick leaves it unchanged. While running, `count_now` is never 0.
- R4: A tick when `count_now` is 1 is an expiry. In one-shot mode (loop flag `wr_data[24]`=0 as stored), after an expiry `running` is 0 and `count_now` is 0. A stopped timer keeps `count_now` at 0.
- R5: In loop mode, an expiry reloads `count_now` from the stored duration and the timer keeps running. If the stored duration is 0 at that point, the timer stops instead.
- R6: An expiry sets `cause` at the same clock edge. `cause` holds its value until a write to address 1 with `wr_data[0]`=1 clears it. If an expiry and a clear happen in the same cycle, the expiry wins.
- R7: `irq` equals `cause` AND the stored enable (`wr_data[25]` of the last address-0 write). With the enable at 0, `irq` never rises.
- R8: A kick-start write whose duration field is 0 leaves the timer stopped, with `count_now` at 0. No expiry follows from it.
- R9: A kick-start write while the timer is running restarts the timer from the duration in that write. A kick-start takes precedence over a tick in the same cycle.
- R10: An address-0 write without kick-start updates the stored duration, loop flag and enable, but does not change `count_now` or `running`. Writes to addresses 2 and 3 have no effect.
- R11: With the internal prescaler selected, ticks occur exactly every `CLKS_PER_MS` core clocks, so a running count changes once per `CLKS_PER_MS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ext | input | 1 | External millisecond tick, one clock wide (used when USE_EXT_TICK=1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 configuration, 1 cause |
| wr_data | input | 32 | Write data: duration [DUR_W-1:0], loop 24, enable 25, kick-start 31; at address 1 bit 0 clears the cause |
| irq | output | 1 | Timer interrupt request |
| cause | output | 1 | Sticky timer cause bit |
| running | output | 1 | Counter is armed |
| count_now | output | DUR_W | Present counter value |

## Verification
The bench builds one instance with USE_EXT_TICK=1 and DUR_W=8. This lets it place ticks in any cycle, including the same cycle as a kick-start, a clear or a configuration change, and it keeps durations short enough that one-shot stops and loop reloads happen often under random stimulus. A second instance uses the internal prescaler with CLKS_PER_MS=5. That value makes the divided tick spacing measurable in a few dozen clocks, so R11 can be checked exactly rather than at the 1 ms default.

// File: rtl/ms_timer_pkg.sv
package ms_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int LOOP_BIT = 24;
    localparam int EN_BIT   = 25;
    localparam int KICK_BIT = 31;
    localparam int CLR_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CONFIG = 2'd0,
        SEL_CAUSE  = 2'd1
    } reg_sel_e;

    typedef struct packed {
        logic cfg_wr;
        logic kick;
        logic loop;
        logic en;
        logic clr;
    } wr_req_t;

    function automatic wr_req_t decode_wr(
        input logic              we,
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        wr_req_t r;
        r.cfg_wr = we && (addr == SEL_CONFIG);
        r.kick   = r.cfg_wr && data[KICK_BIT];
        r.loop   = data[LOOP_BIT];
        r.en     = data[EN_BIT];
        r.clr    = we && (addr == SEL_CAUSE) && data[CLR_BIT];
        return r;
    endfunction

endpackage

// File: rtl/mst_tick_gen.sv
module mst_tick_gen #(
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int CLKS_PER_MS  = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ext,
    output logic tick
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

    generate
        if (USE_EXT_TICK) begin : g_ext
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign tick = tick_ext;
        end else begin : g_presc
            logic [CW-1:0] div_q;
            logic          wrap;
            logic          unused_ext;
            assign unused_ext = tick_ext;
            assign wrap = (div_q == CW'(CLKS_PER_MS - 1));
            always_ff @(posedge clk) begin
                if (rst)       div_q <= '0;
                else if (wrap) div_q <= '0;
                else           div_q <= div_q + 1'b1;
            end
            assign tick = wrap;
        end
    endgenerate
endmodule

// File: rtl/mst_cfg_regs.sv
module mst_cfg_regs
    import ms_timer_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic [DUR_W-1:0] wdur,
    output logic [DUR_W-1:0] dur_q,
    output logic             loop_q,
    output logic             en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q  <= '0;
            loop_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (req.cfg_wr) begin
            dur_q  <= wdur;
            loop_q <= req.loop;
            en_q   <= req.en;
        end
    end
endmodule

// File: rtl/mst_down_counter.sv
module mst_down_counter #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic [DUR_W-1:0] kick_dur,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur_q,
    input  logic             loop_q,
    output logic [DUR_W-1:0] count_q,
    output logic             run_q,
    output logic             expire
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic step;
    assign step   = !kick && tick && run_q;
    assign expire = step && (count_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (kick) begin
            if (kick_dur != '0) begin
                count_q <= kick_dur;
                run_q   <= 1'b1;
            end else begin
                count_q <= '0;
                run_q   <= 1'b0;
            end
        end else if (expire) begin
            if (loop_q && (dur_q != '0)) begin
                count_q <= dur_q;
            end else begin
                count_q <= '0;
                run_q   <= 1'b0;
            end
        end else if (step) begin
            count_q <= count_q - ONE;
        end
    end
endmodule

// File: rtl/mst_cause_bit.sv
module mst_cause_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic cause_q
);
    always_ff @(posedge clk) begin
        if (rst)      cause_q <= 1'b0;
        else if (set) cause_q <= 1'b1;
        else if (clr) cause_q <= 1'b0;
    end
endmodule

// File: rtl/ms_timer_irq.sv
module ms_timer_irq
    import ms_timer_pkg::*;
#(
    parameter int DUR_W        = 16,
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int CLKS_PER_MS  = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_ext,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic              cause,
    output logic              running,
    output logic [DUR_W-1:0]  count_now
);
    wr_req_t          req;
    logic             tick;
    logic [DUR_W-1:0] dur_q;
    logic             loop_q;
    logic             en_q;
    logic             expire;

    assign req = decode_wr(wr_en, wr_addr, wr_data);

    mst_tick_gen #(
        .USE_EXT_TICK (USE_EXT_TICK),
        .CLKS_PER_MS  (CLKS_PER_MS)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .tick_ext (tick_ext),
        .tick     (tick)
    );

    mst_cfg_regs #(.DUR_W(DUR_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdur   (wr_data[DUR_W-1:0]),
        .dur_q  (dur_q),
        .loop_q (loop_q),
        .en_q   (en_q)
    );

    mst_down_counter #(.DUR_W(DUR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .kick     (req.kick),
        .kick_dur (wr_data[DUR_W-1:0]),
        .tick     (tick),
        .dur_q    (dur_q),
        .loop_q   (loop_q),
        .count_q  (count_now),
        .run_q    (running),
        .expire   (expire)
    );

    mst_cause_bit u_cause (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr     (req.clr),
        .cause_q (cause)
    );

    assign irq = cause && en_q;
endmodule

// File: rtl/ms_timer_irq_chk.sv
module ms_timer_irq_chk
    import ms_timer_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic              cause,
    input logic              running,
    input logic [DUR_W-1:0]  count_now
);
    logic kick_w, clr_w;
    assign kick_w = wr_en && (wr_addr == 2'd0) && wr_data[KICK_BIT];
    assign clr_w  = wr_en && (wr_addr == 2'd1) && wr_data[CLR_BIT];

    assert_kick_load_R2: assert property (@(posedge clk) disable iff (rst)
        (kick_w && (wr_data[DUR_W-1:0] != '0)) |=>
        (running && (count_now == $past(wr_data[DUR_W-1:0]))));

    assert_run_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        running |-> (count_now != '0));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !running |-> (count_now == '0));

    assert_cause_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cause && !clr_w) |=> cause);

    assert_cause_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cause) |-> $past(running));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> cause);

    assert_zero_kick_R8: assert property (@(posedge clk) disable iff (rst)
        (kick_w && (wr_data[DUR_W-1:0] == '0)) |=> (!running && (count_now == '0)));
endmodule

bind ms_timer_irq ms_timer_irq_chk #(.DUR_W(DUR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .cause     (cause),
    .running   (running),
    .count_now (count_now)
);

// File: tb/ms_timer_irq_bench.sv
module ms_timer_irq_bench;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int PDIV   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    logic          tick_ext = 1'b0, wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          irq, cause, running;
    logic [DW-1:0] count_now;

    logic          p_wr_en = 1'b0;
    logic [1:0]    p_wr_addr = '0;
    logic [31:0]   p_wr_data = '0;
    logic          p_irq, p_cause, p_running;
    logic [DW-1:0] p_count;

    ms_timer_irq #(.DUR_W(DW), .USE_EXT_TICK(1'b1), .CLKS_PER_MS(PDIV)) u_ms_timer_irq (
        .clk(clk), .rst(rst), .tick_ext(tick_ext), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq), .cause(cause), .running(running), .count_now(count_now));

    ms_timer_irq #(.DUR_W(DW), .USE_EXT_TICK(1'b0), .CLKS_PER_MS(PDIV)) u_presc (
        .clk(clk), .rst(rst), .tick_ext(1'b0), .wr_en(p_wr_en), .wr_addr(p_wr_addr),
        .wr_data(p_wr_data), .irq(p_irq), .cause(p_cause), .running(p_running), .count_now(p_count));

    int n_checks = 0, n_fail = 0;

    // reference state
    logic [DW-1:0] m_dur = '0, m_cnt = '0;
    logic          m_loop = 0, m_en = 0, m_run = 0, m_cause = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cfg_word(input bit kick, input bit en, input bit loop, input logic [DW-1:0] d);
        return {kick, 5'b0, en, loop, 16'b0, d};
    endfunction

    function automatic bit fn_expire(input bit t, input bit kick, input bit run, input logic [DW-1:0] c);
        return !kick && t && run && (c == 1);
    endfunction

    function automatic logic [DW-1:0] fn_next_cnt(input bit t, input bit kick, input logic [DW-1:0] kd,
                                                  input bit run, input logic [DW-1:0] c,
                                                  input bit loop, input logic [DW-1:0] d);
        if (kick) return kd;
        if (t && run) begin
            if (c == 1) return (loop && d != 0) ? d : '0;
            return c - 1;
        end
        return c;
    endfunction

    task automatic model(input bit t, input bit we, input logic [1:0] a, input logic [31:0] d);
        bit kick, cfg, clr, ex;
        logic [DW-1:0] nc;
        cfg  = we && a == 2'd0;
        kick = cfg && d[31];
        clr  = we && a == 2'd1 && d[0];
        ex   = fn_expire(t, kick, m_run, m_cnt);
        nc   = fn_next_cnt(t, kick, d[DW-1:0], m_run, m_cnt, m_loop, m_dur);
        m_cnt = nc;
        m_run = (nc != 0);
        m_cause = ex | (m_cause & !clr);
        if (cfg) begin
            m_dur = d[DW-1:0]; m_loop = d[24]; m_en = d[25];
        end
    endtask

    // called at a negedge; returns at the next negedge after comparing
    task automatic step(input bit t, input bit we, input logic [1:0] a, input logic [31:0] d);
        tick_ext = t; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model(t, we, a, d);
        @(negedge clk);
        tick_ext = 0; wr_en = 0;
        chk("R3 count", int'(count_now), int'(m_cnt));
        chk("R4 running", int'(running), int'(m_run));
        chk("R6 cause", int'(cause), int'(m_cause));
        chk("R7 irq", int'(irq), int'(m_cause & m_en));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0);
    endtask

    task automatic clear_cause();
        step(0, 1, 2'd1, 32'd1);
    endtask

    initial begin
        #(PERIOD*150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 running", int'(running), 0);
        chk("R1 count", int'(count_now), 0);
        chk("R1 cause", int'(cause), 0);
        chk("R1 irq", int'(irq), 0);

        // R2, R4: one-shot of 3 ticks
        step(0, 1, 0, cfg_word(1, 1, 0, 8'd3));
        chk("R2 load", int'(count_now), 3);
        step(0, 0, 0, 0);
        chk("R3 hold without tick", int'(count_now), 3);
        ticks(3);
        chk("R4 stopped", int'(running), 0);
        chk("R6 set on expiry", int'(cause), 1);
        chk("R7 irq enabled", int'(irq), 1);
        ticks(2);
        chk("R4 stays zero", int'(count_now), 0);
        clear_cause();
        chk("R6 cleared", int'(cause), 0);

        // R5 loop
        step(0, 1, 0, cfg_word(1, 0, 1, 8'd2));
        ticks(2);
        chk("R5 reload", int'(count_now), 2);
        chk("R5 still running", int'(running), 1);
        chk("R7 irq disabled", int'(irq), 0);
        // R6 set wins over clear: count is 2, one tick then tick+clear
        ticks(1);
        step(1, 1, 2'd1, 32'd1);
        chk("R6 set beats clear", int'(cause), 1);

        // R10 config without kick, and ignored addresses
        step(0, 1, 0, cfg_word(0, 1, 1, 8'd7));
        chk("R10 count unchanged", int'(count_now), 2);
        step(0, 1, 2'd2, 32'hFFFF_FFFF);
        step(0, 1, 2'd3, 32'hFFFF_FFFF);
        chk("R10 other addr", int'(count_now), 2);
        ticks(2);
        chk("R5 reload new dur", int'(count_now), 7);

        // R9 restart while running, kick beats tick
        step(1, 1, 0, cfg_word(1, 1, 0, 8'd5));
        chk("R9 restart", int'(count_now), 5);

        // R8 zero duration kick
        step(0, 1, 0, cfg_word(1, 1, 1, 8'd0));
        chk("R8 stopped", int'(running), 0);
        clear_cause();
        ticks(4);
        chk("R8 no expiry", int'(cause), 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit t, we; logic [1:0] a; logic [31:0] d; int r;
            t = ($urandom_range(2) == 0);
            we = ($urandom_range(5) == 0);
            r = $urandom_range(9);
            a = (r < 6) ? 2'd0 : (r < 9) ? 2'd1 : 2'($urandom_range(3));
            d = cfg_word($urandom_range(1) == 1, $urandom_range(3) != 0, $urandom_range(1) == 1,
                         8'($urandom_range(5)));
            if (a == 2'd1) d = {31'b0, 1'($urandom_range(1))};
            step(t, we, a, d);
        end

        // R11 prescaler spacing
        p_wr_en = 1; p_wr_addr = 0; p_wr_data = cfg_word(1, 0, 1, 8'd6);
        @(posedge clk); @(negedge clk);
        p_wr_en = 0;
        chk("R11 loaded", int'(p_count), 6);
        begin
            logic [DW-1:0] prev;
            int n;
            prev = p_count; n = 0;
            while (p_count == prev && n < 20) begin @(negedge clk); n++; end
            for (int k = 0; k < 4; k++) begin
                prev = p_count; n = 0;
                while (p_count == prev && n < 20) begin @(negedge clk); n++; end
                chk("R11 tick spacing", n, PDIV);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule